// File: doc/BRIEF.md
# Word-Clock Frame Rate Monitor

This block watches the word clock of a serial audio link on which it is the slave. Each rising word-clock edge marks a frame start. On that edge the block copies a free-running time-base counter into a timestamp register and pulses a strobe. A downstream ratio estimator can take the stream of timestamps straight from these outputs. The counter advances once per clock cycle, and the clock is taken to run at `TB_HZ` (nominally 100 MHz). The block works out the average frame period over a window of frames, snaps that average to one of six standard audio rates, and reports the result as a small code.

A new nominal rate takes effect only after two consecutive windows agree on it. When the reported rate moves to a known value, the block emits a one-cycle reconfiguration request for the downstream converter. If the word clock goes silent for longer than a millisecond, the rate is declared unknown at once.

A mute output is held high for a programmable number of milliseconds, both after reset and after every reconfiguration request. The mute time is counted in 10 µs ticks derived from the same time base.

Top module: `frame_rate_monitor`

## Requirements
- R1: Every rising edge of `wclk_i` produces one `frame_stb_o` pulse. `frame_ts_o` is valid with that pulse. The difference between consecutive timestamps equals the frame period in clock cycles.
- R2: The period is averaged over 16 frames (2^`AVG_LOG2`) and accepted when it lies within ±2 % of a nominal rate. The codes on `rate_o` are 0 = unknown, 1 = 44.1 kHz, 2 = 48 kHz, 3 = 88.2 kHz, 4 = 96 kHz, 5 = 176.4 kHz, 6 = 192 kHz.
- R3: `rate_o` changes only after two consecutive measurement windows give the same new class. A single differing window leaves it unchanged.
- R4: `reconfig_o` is a one-cycle pulse, raised in the same cycle that `rate_o` takes a new known (non-zero) code, and only then.
- R5: A period matching no nominal rate for two windows drives `rate_o` to 0 without a reconfiguration request.
- R6: More than 1 ms (`TB_HZ`/1000 cycles) without a word-clock edge forces `rate_o` to 0 without a request. The next edge restarts the measurement.
- R7: After reset, `mute_o` stays high for `mute_ms_i` × 100 ticks of 10 µs and falls 1 + `mute_ms_i`·`TB_HZ`/1000 cycles after reset release.
- R8: A reconfiguration request reloads the mute time even while a countdown is running. `mute_o` then falls `mute_ms_i`·`TB_HZ`/1000 cycles after the cycle following the request.
- R9: During and straight after reset, `rate_o` is 0, `reconfig_o` and `frame_stb_o` are 0, and `mute_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock, one counter tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Word clock from the link, asynchronous |
| mute_ms_i | input | MS_W | Mute length in milliseconds |
| frame_stb_o | output | 1 | One-cycle pulse per detected frame start |
| frame_ts_o | output | TS_W | Time-base count captured at the frame start |
| rate_o | output | 3 | Detected nominal rate code |
| reconfig_o | output | 1 | One-cycle request to reconfigure the converter |
| mute_o | output | 1 | Output mute |

## Verification
The mute countdown from reset and the reload caused by a committed rate change can overlap: the reload arrives while the startup count is still running. The bench provokes this by resetting with a 2 ms mute and starting a steady 48 kHz word clock about 11 000 cycles later. The rate then commits well before the startup count would expire. The test is judged by checking that mute is still high past the point where the startup count alone would have ended. Mute must then fall exactly 2 ms after the request.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [2:0] {
    RATE_NONE  = 3'd0,
    RATE_44K1  = 3'd1,
    RATE_48K   = 3'd2,
    RATE_88K2  = 3'd3,
    RATE_96K   = 3'd4,
    RATE_176K4 = 3'd5,
    RATE_192K  = 3'd6
  } rate_e;

  localparam int unsigned NUM_RATES = 6;

  function automatic longint unsigned nominal_hz(rate_e r);
    case (r)
      RATE_44K1:  return 64'd44100;
      RATE_48K:   return 64'd48000;
      RATE_88K2:  return 64'd88200;
      RATE_96K:   return 64'd96000;
      RATE_176K4: return 64'd176400;
      RATE_192K:  return 64'd192000;
      default:    return 64'd0;
    endcase
  endfunction

  // period*hz is compared with the time-base frequency, scaled by 100
  function automatic logic in_window(longint unsigned per, longint unsigned hz,
                                     longint unsigned tb, longint unsigned tol_pct);
    longint unsigned prod;
    prod = per * hz * 64'd100;
    return (prod >= tb * (64'd100 - tol_pct)) && (prod <= tb * (64'd100 + tol_pct));
  endfunction

  function automatic rate_e classify(longint unsigned per, longint unsigned tb,
                                     longint unsigned tol_pct);
    rate_e res;
    res = RATE_NONE;
    for (int i = 1; i <= int'(NUM_RATES); i++) begin
      if (in_window(per, nominal_hz(rate_e'(i)), tb, tol_pct)) res = rate_e'(i);
    end
    return res;
  endfunction

endpackage

// File: rtl/fr_edge_stamp.sv
module fr_edge_stamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wclk_i,
  output logic            frame_stb_o,
  output logic [TS_W-1:0] frame_ts_o
);
  logic [TS_W-1:0] tb_cnt;
  logic [2:0]      sync_q;
  logic            rise;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_cnt      <= '0;
      sync_q      <= '0;
      frame_stb_o <= 1'b0;
      frame_ts_o  <= '0;
    end else begin
      tb_cnt      <= tb_cnt + 1'b1;
      sync_q      <= {sync_q[1:0], wclk_i};
      frame_stb_o <= rise;
      if (rise) frame_ts_o <= tb_cnt;
    end
  end

  // R1
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |=> !frame_stb_o);

endmodule

// File: rtl/fr_period.sv
module fr_period #(
  parameter int TS_W       = 32,
  parameter int PER_W      = 24,
  parameter int AVG_LOG2   = 4,
  parameter int LOSS_TICKS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb_i,
  input  logic [TS_W-1:0]  frame_ts_i,
  output logic             meas_stb_o,
  output logic [PER_W-1:0] avg_per_o,
  output logic             loss_stb_o
);
  localparam int IDLE_W = $clog2(LOSS_TICKS + 1);
  localparam logic [IDLE_W-1:0] LOSS_L = IDLE_W'(LOSS_TICKS);

  logic                anchored;
  logic [TS_W-1:0]     anchor;
  logic [AVG_LOG2-1:0] fcnt;
  logic [IDLE_W-1:0]   idle;
  logic [TS_W-1:0]     span;

  assign span = frame_ts_i - anchor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anchored   <= 1'b0;
      anchor     <= '0;
      fcnt       <= '0;
      idle       <= '0;
      meas_stb_o <= 1'b0;
      avg_per_o  <= '0;
      loss_stb_o <= 1'b0;
    end else begin
      meas_stb_o <= 1'b0;
      loss_stb_o <= 1'b0;
      if (frame_stb_i) begin
        idle <= '0;
        if (!anchored) begin
          anchored <= 1'b1;
          anchor   <= frame_ts_i;
          fcnt     <= '0;
        end else begin
          fcnt <= fcnt + 1'b1;
          if (fcnt == '1) begin
            meas_stb_o <= 1'b1;
            avg_per_o  <= PER_W'(span >> AVG_LOG2);
            anchor     <= frame_ts_i;
          end
        end
      end else if (idle < LOSS_L) begin
        idle <= idle + 1'b1;
        if (idle == LOSS_L - 1'b1) begin
          loss_stb_o <= 1'b1;
          anchored   <= 1'b0;
        end
      end
    end
  end

  // R2
  meas_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb_o |-> $past(frame_stb_i));

  // R6
  loss_needs_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_stb_o |-> !$past(frame_stb_i));

endmodule

// File: rtl/fr_judge.sv
module fr_judge
  import fr_pkg::*;
#(
  parameter int PER_W   = 24,
  parameter longint unsigned TB_HZ   = 100000000,
  parameter int TOL_PCT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_stb_i,
  input  logic [PER_W-1:0] avg_per_i,
  input  logic             loss_stb_i,
  output logic [2:0]       rate_o,
  output logic             reconfig_o
);
  rate_e cls, prev, cur;
  logic  commit;

  assign cls    = classify(64'(avg_per_i), TB_HZ, 64'(TOL_PCT));
  assign commit = meas_stb_i && (cls == prev) && (cls != cur);
  assign rate_o = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= RATE_NONE;
      cur        <= RATE_NONE;
      reconfig_o <= 1'b0;
    end else begin
      reconfig_o <= 1'b0;
      if (loss_stb_i) begin
        prev <= RATE_NONE;
        cur  <= RATE_NONE;
      end else if (meas_stb_i) begin
        prev <= cls;
        if (commit) begin
          cur        <= cls;
          reconfig_o <= (cls != RATE_NONE);
        end
      end
    end
  end

  // R4
  reconfig_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_o |-> (rate_o != 3'd0) && (rate_o != $past(rate_o)));

  // R3
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_stb_i && !loss_stb_i) |=> $stable(rate_o));

  // R6
  loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_stb_i |=> (rate_o == 3'd0) && !reconfig_o);

  // R5
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb_i && cls == RATE_NONE) |=> !reconfig_o);

endmodule

// File: rtl/fr_mute.sv
module fr_mute #(
  parameter int MS_W      = 8,
  parameter int TICK_DIV  = 1000,
  parameter int TICKS_MS  = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MS_W-1:0] mute_ms_i,
  input  logic            reconfig_i,
  output logic            mute_o
);
  localparam int DIV_W = $clog2(TICK_DIV);
  localparam int CNT_W = MS_W + $clog2(TICKS_MS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] pre;
  logic [CNT_W-1:0] left;
  logic             boot;
  logic             tick;

  assign tick   = (pre == DIV_LAST);
  assign mute_o = boot || (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot <= 1'b1;
      left <= '0;
      pre  <= '0;
    end else if (boot || reconfig_i) begin
      boot <= 1'b0;
      left <= CNT_W'(mute_ms_i) * CNT_W'(TICKS_MS);
      pre  <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && left != '0) left <= left - 1'b1;
    end
  end

  // R8
  reload_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reconfig_i && mute_ms_i != '0) |=> mute_o);

  // R7
  unmute_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_o) |-> $past(tick));

endmodule

// File: rtl/frame_rate_monitor.sv
module frame_rate_monitor #(
  parameter longint unsigned TB_HZ = 100000000,
  parameter int TS_W     = 32,
  parameter int PER_W    = 24,
  parameter int AVG_LOG2 = 4,
  parameter int TOL_PCT  = 2,
  parameter int MS_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wclk_i,
  input  logic [MS_W-1:0] mute_ms_i,
  output logic            frame_stb_o,
  output logic [TS_W-1:0] frame_ts_o,
  output logic [2:0]      rate_o,
  output logic            reconfig_o,
  output logic            mute_o
);
  localparam int TICK_HZ    = 100000;
  localparam int TICK_DIV   = int'(TB_HZ / TICK_HZ);
  localparam int TICKS_MS   = TICK_HZ / 1000;
  localparam int LOSS_TICKS = int'(TB_HZ / 1000);

  logic             meas_stb;
  logic [PER_W-1:0] avg_per;
  logic             loss_stb;

  fr_edge_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .wclk_i(wclk_i),
    .frame_stb_o(frame_stb_o), .frame_ts_o(frame_ts_o)
  );

  fr_period #(.TS_W(TS_W), .PER_W(PER_W), .AVG_LOG2(AVG_LOG2),
              .LOSS_TICKS(LOSS_TICKS)) u_period (
    .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb_o), .frame_ts_i(frame_ts_o),
    .meas_stb_o(meas_stb), .avg_per_o(avg_per), .loss_stb_o(loss_stb)
  );

  fr_judge #(.PER_W(PER_W), .TB_HZ(TB_HZ), .TOL_PCT(TOL_PCT)) u_judge (
    .clk(clk), .rst_n(rst_n), .meas_stb_i(meas_stb), .avg_per_i(avg_per),
    .loss_stb_i(loss_stb), .rate_o(rate_o), .reconfig_o(reconfig_o)
  );

  fr_mute #(.MS_W(MS_W), .TICK_DIV(TICK_DIV), .TICKS_MS(TICKS_MS)) u_mute (
    .clk(clk), .rst_n(rst_n), .mute_ms_i(mute_ms_i), .reconfig_i(reconfig_o),
    .mute_o(mute_o)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rate_o == 3'd0) && mute_o && !reconfig_o);

endmodule

// File: tb/test_frame_rate_monitor.sv
module test_frame_rate_monitor;
  localparam longint unsigned TB_HZ = 10000000;
  localparam int MS_CYC = 10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wclk = 1'b0;
  logic [7:0]  mute_ms = 8'd1;
  logic        frame_stb;
  logic [31:0] frame_ts;
  logic [2:0]  rate;
  logic        reconfig;
  logic        mute;

  int errors = 0, checks = 0, cyc = 0;
  int exp_q[$];
  int per_q[$];
  int last_p = 0;
  int n_cfg = 0, n_push = 0, last_cfg = 0;
  logic [31:0] prev_ts = '0;

  frame_rate_monitor #(.TB_HZ(TB_HZ)) i_frame_rate_monitor (
    .clk(clk), .rst_n(rst_n), .wclk_i(wclk), .mute_ms_i(mute_ms),
    .frame_stb_o(frame_stb), .frame_ts_o(frame_ts), .rate_o(rate),
    .reconfig_o(reconfig), .mute_o(mute)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic send_frames(int p, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wclk = 1'b1;
      per_q.push_back(last_p);
      repeat (p / 2) @(negedge clk);
      wclk = 1'b0;
      repeat (p - p / 2 - 1) @(negedge clk);
      last_p = p;
    end
  endtask

  task automatic send_idle(int n);
    last_p = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cfg(int code);
    exp_q.push_back(code);
    n_push++;
  endtask

  task automatic do_reset(int ms, output int rel);
    @(negedge clk);
    rst_n = 1'b0;
    mute_ms = 8'(ms);
    per_q.delete();
    last_p = 0;
    repeat (3) @(negedge clk);
    check("R9 rate", rate == 3'd0, rate, 0);
    check("R9 mute", mute == 1'b1, mute, 1);
    check("R9 reconfig", reconfig == 1'b0, reconfig, 0);
    check("R9 frame_stb", frame_stb == 1'b0, frame_stb, 0);
    rst_n = 1'b1;
    rel = cyc;
  endtask

  // monitor: reconfig scoreboard and timestamp spacing
  always @(negedge clk) begin
    if (rst_n && reconfig) begin
      n_cfg++;
      last_cfg = cyc;
      if (exp_q.size() == 0) begin
        check("R4 unexpected request", 1'b0, rate, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R2 R4 rate at request", rate == 3'(e), rate, e);
      end
    end
    if (rst_n && frame_stb) begin
      int e;
      e = (per_q.size() != 0) ? per_q.pop_front() : -1;
      if (e > 0) check("R1 timestamp step", (frame_ts - prev_ts) == 32'(e), frame_ts - prev_ts, e);
      if (e < 0) check("R1 stray strobe", 1'b0, 1, 0);
      prev_ts = frame_ts;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, cfg_before;
    // R7: startup mute of 1 ms
    do_reset(1, c0);
    wait_cyc(c0 + MS_CYC - 10);
    check("R7 mute still on", mute == 1'b1, mute, 1);
    wait_cyc(c0 + MS_CYC + 10);
    check("R7 mute released", mute == 1'b0, mute, 0);

    // R8: rate commit while the startup mute is still counting
    do_reset(2, c0);
    expect_cfg(2);
    fork
      begin
        send_idle(11000);
        send_frames(208, 140);
      end
      begin
        wait_cyc(c0 + 2 * MS_CYC + 10);
        check("R8 mute extended", mute == 1'b1, mute, 1);
        while (n_cfg < 1) @(negedge clk);
        wait_cyc(last_cfg + 2 * MS_CYC - 10);
        check("R8 mute before reload end", mute == 1'b1, mute, 1);
        wait_cyc(last_cfg + 2 * MS_CYC + 10);
        check("R8 mute after reload end", mute == 1'b0, mute, 0);
      end
    join
    check("R2 48k held", rate == 3'd2, rate, 2);

    // R2: walk through further rates
    expect_cfg(1); send_frames(227, 50);
    check("R2 44.1k", rate == 3'd1, rate, 1);
    expect_cfg(3); send_frames(113, 50);
    check("R2 88.2k", rate == 3'd3, rate, 3);
    expect_cfg(4); send_frames(104, 50);
    check("R2 96k", rate == 3'd4, rate, 4);

    // R6: loss of word clock
    cfg_before = n_cfg;
    send_idle(12000);
    check("R6 rate unknown on loss", rate == 3'd0, rate, 0);
    check("R6 no request on loss", n_cfg == cfg_before, n_cfg, cfg_before);

    // R3: one stray window must not move the rate
    expect_cfg(4);
    send_frames(104, 32);
    send_frames(52, 16);
    send_frames(104, 32);
    check("R3 rate kept", rate == 3'd4, rate, 4);
    check("R3 single request", n_cfg == cfg_before + 1, n_cfg, cfg_before + 1);
    expect_cfg(6); send_frames(52, 50);
    check("R3 192k after two windows", rate == 3'd6, rate, 6);

    // R5: period off every nominal
    cfg_before = n_cfg;
    send_frames(150, 50);
    check("R5 rate unknown", rate == 3'd0, rate, 0);
    check("R5 no request", n_cfg == cfg_before, n_cfg, cfg_before);
    expect_cfg(5); send_frames(57, 50);
    check("R2 176.4k", rate == 3'd5, rate, 5);

    repeat (10) @(negedge clk);
    check("R4 all requests seen", exp_q.size() == 0, exp_q.size(), 0);
    check("R4 request count", n_cfg == n_push, n_cfg, n_push);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule